// File: doc/BRIEF.md
# Four-Channel Wiper Code and Preset Bank

This block holds the digital settings of four potentiometer wipers. Each channel owns one volatile 8-bit wiper code and four 8-bit preset slots. A serial front end decodes host commands and hands them over on a valid/ready command stream. The bank executes each command: it reads or writes a wiper code or a preset, copies a preset into its wiper or a wiper into a preset, does the same copy on all four channels at once, or enters a stepping mode. In stepping mode, each serial clock pulse moves one wiper up or down by one code.

The four wiper codes leave the block on a flat bus that drives the tap decoders. Code 00 selects the tap at the low terminal and code FF selects the tap at the high terminal. The preset slots stand in for non-volatile storage and are modelled as flops that reset does not clear. While reset is held, every wiper reloads from preset slot 0 of its own channel. A separate write controller grants preset writes. The bank therefore exerts back-pressure on any command that would write a preset until that grant is present. Commands that only touch wiper codes, or only read, are always taken.

Read results come back on a one-cycle `rd_valid` pulse with no back-pressure; the consumer must take the result in that cycle.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_n` is low, each wiper code loads the value of preset slot 0 of its own channel; after release the wipers hold those values. During reset `cmd_ready` and `rd_valid` are 0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. Op 1 (write wiper) loads `cmd_data` into the wiper of channel `cmd_pot`, visible one cycle later. The other wipers do not change.
- R3: Op 0 (read wiper) and op 2 (read preset) produce `rd_valid`=1 in the cycle after they are taken. `rd_data` then holds the wiper code of `cmd_pot`, or preset `cmd_sel` of `cmd_pot`, as it stood before that edge.
- R4: Ops 3, 5 and 7 write presets, and `cmd_ready` for them equals `nv_grant`. For every other op `cmd_ready` is 1 outside reset. A command that is not taken has no effect.
- R5: Op 4 copies preset `cmd_sel` of channel `cmd_pot` into that channel's wiper.
- R6: Op 3 writes `cmd_data` into preset `cmd_sel` of channel `cmd_pot`. Op 5 copies that channel's wiper into that preset.
- R7: Op 6 copies preset `cmd_sel` into the wiper on all four channels at once, and `cmd_pot` is ignored.
- R8: Op 7 copies every wiper into preset `cmd_sel` of its own channel, and `cmd_pot` is ignored.
- R9: Op 8 enters step mode for channel `cmd_pot`. While in step mode, each cycle with `step_pulse`=1 moves that wiper up by one if `step_up`=1 and down by one otherwise. A wiper load taken in the same cycle takes priority over the step.
- R10: Stepping saturates: up from FF stays FF and down from 00 stays 00.
- R11: `sel_end`=1 leaves step mode; the exit takes priority over an entry in the same cycle. Pulses outside step mode, and pulses aimed at other channels, change no wiper.
- R12: `cmd_sel` picks the preset slot, with 0 selecting slot 0 and 3 selecting slot 3. Op codes 9 to 15 are taken and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; recalls preset 0 into each wiper |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 4 | Operation code (0..8 defined) |
| cmd_pot | input | 2 | Channel select |
| cmd_sel | input | 2 | Preset slot select |
| cmd_data | input | 8 | Write data |
| nv_grant | input | 1 | Write controller allows a preset write |
| step_pulse | input | 1 | One serial clock pulse in step mode |
| step_up | input | 1 | Step direction, 1 = toward FF |
| sel_end | input | 1 | Chip select released; ends step mode |
| rd_valid | output | 1 | Read result present (one cycle) |
| rd_data | output | 8 | Read result |
| wiper_codes | output | 32 | Wiper codes, channel p at bits 8p+7:8p |

## Verification
Every wiper and preset update, and every step, lands on the clock edge where it is taken. The new wiper code is therefore visible one cycle after the inputs are driven, and a read result appears on `rd_valid`/`rd_data` that same cycle later. The bench drives inputs after a falling edge and predicts `cmd_ready` combinationally before the rising edge. It updates its own model of wipers, presets and step state for that edge, and compares all outputs at the following falling edge. Reset is checked the same way, as a one-edge recall of each channel's preset 0 into its wiper.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;
  typedef enum logic [3:0] {
    OP_RD_WIPER  = 4'd0,
    OP_WR_WIPER  = 4'd1,
    OP_RD_PRESET = 4'd2,
    OP_WR_PRESET = 4'd3,
    OP_PRE2WIP   = 4'd4,
    OP_WIP2PRE   = 4'd5,
    OP_ALL_P2W   = 4'd6,
    OP_ALL_W2P   = 4'd7,
    OP_STEP      = 4'd8
  } op_e;

  function automatic logic writes_preset(input logic [3:0] op);
    return (op == OP_WR_PRESET) || (op == OP_WIP2PRE) || (op == OP_ALL_W2P);
  endfunction
endpackage

// File: rtl/wiper_chan.sv
module wiper_chan #(
  parameter int W    = 8,
  parameter int NPRE = 4,
  localparam int SW  = $clog2(NPRE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wip_we,
  input  logic          wip_from_pre,
  input  logic          pre_we,
  input  logic          pre_from_wip,
  input  logic [SW-1:0] sel,
  input  logic [W-1:0]  din,
  input  logic          step,
  input  logic          step_up,
  output logic [W-1:0]  wip,
  output logic [W-1:0]  pre_q
);
  localparam logic [W-1:0] MAXC = {W{1'b1}};

  logic [W-1:0] pre [NPRE];

  assign pre_q = pre[sel];

  always_ff @(posedge clk) begin
    if (!rst_n)
      wip <= pre[0];
    else if (wip_we)
      wip <= wip_from_pre ? pre[sel] : din;
    else if (step) begin
      if (step_up && wip != MAXC)
        wip <= wip + W'(1);
      else if (!step_up && wip != '0)
        wip <= wip - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (pre_we)
      pre[sel] <= pre_from_wip ? wip : din;
  end

  p_step_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wip_we && step_up && wip != MAXC) |=> wip == $past(wip) + W'(1));

  p_step_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wip_we && ((step_up && wip == MAXC) || (!step_up && wip == '0)))
      |=> $stable(wip));
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl #(
  parameter int NPOTS = 4,
  localparam int PW   = $clog2(NPOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic [PW-1:0] pot_in,
  input  logic          sel_end,
  input  logic          pulse,
  output logic [NPOTS-1:0] step_vec
);
  logic          active;
  logic [PW-1:0] target;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      target <= '0;
    end else if (sel_end) begin
      active <= 1'b0;
    end else if (enter) begin
      active <= 1'b1;
      target <= pot_in;
    end
  end

  for (genvar p = 0; p < NPOTS; p++) begin : g_vec
    assign step_vec[p] = active && pulse && (target == PW'(p));
  end

  p_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_end |=> (step_vec == '0));

  p_single_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_vec));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_bank_pkg::*;
#(
  parameter int NPOTS = 4,
  parameter int W     = 8,
  parameter int NPRE  = 4,
  localparam int PW   = $clog2(NPOTS),
  localparam int SW   = $clog2(NPRE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [3:0]         cmd_op,
  input  logic [PW-1:0]      cmd_pot,
  input  logic [SW-1:0]      cmd_sel,
  input  logic [W-1:0]       cmd_data,
  input  logic               nv_grant,
  input  logic               step_pulse,
  input  logic               step_up,
  input  logic               sel_end,
  output logic               rd_valid,
  output logic [W-1:0]       rd_data,
  output logic [NPOTS*W-1:0] wiper_codes
);
  logic             take;
  logic             is_read;
  logic [NPOTS-1:0] step_vec;
  logic [W-1:0]     wip_q [NPOTS];
  logic [W-1:0]     pre_q [NPOTS];

  assign cmd_ready = rst_n && (!writes_preset(cmd_op) || nv_grant);
  assign take      = cmd_valid && cmd_ready;
  assign is_read   = (cmd_op == OP_RD_WIPER) || (cmd_op == OP_RD_PRESET);

  step_ctrl #(.NPOTS(NPOTS)) u_step (
    .clk(clk), .rst_n(rst_n),
    .enter(take && cmd_op == OP_STEP), .pot_in(cmd_pot),
    .sel_end(sel_end), .pulse(step_pulse), .step_vec(step_vec)
  );

  for (genvar p = 0; p < NPOTS; p++) begin : g_ch
    logic hit, w_we, p_we;
    assign hit  = (cmd_pot == PW'(p));
    assign w_we = take && (((cmd_op == OP_WR_WIPER || cmd_op == OP_PRE2WIP) && hit)
                           || cmd_op == OP_ALL_P2W);
    assign p_we = take && (((cmd_op == OP_WR_PRESET || cmd_op == OP_WIP2PRE) && hit)
                           || cmd_op == OP_ALL_W2P);

    wiper_chan #(.W(W), .NPRE(NPRE)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wip_we(w_we), .wip_from_pre(cmd_op != OP_WR_WIPER),
      .pre_we(p_we), .pre_from_wip(cmd_op != OP_WR_PRESET),
      .sel(cmd_sel), .din(cmd_data),
      .step(step_vec[p]), .step_up(step_up),
      .wip(wip_q[p]), .pre_q(pre_q[p])
    );

    assign wiper_codes[p*W +: W] = wip_q[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= take && is_read;
      if (take && is_read)
        rd_data <= (cmd_op == OP_RD_WIPER) ? wip_q[cmd_pot] : pre_q[cmd_pot];
    end
  end

  p_read_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_read) |=> rd_valid);

  p_no_stray_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(take && is_read)) |=> !rd_valid);
endmodule

// File: tb/tb_wiper_bank.sv
module tb_wiper_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, nv_grant = 1'b0, step_pulse = 1'b0, step_up = 1'b0, sel_end = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [1:0]  cmd_pot = '0, cmd_sel = '0;
  logic [7:0]  cmd_data = '0;
  logic        cmd_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [31:0] wiper_codes;

  int vecs = 0, miss = 0;
  logic [7:0] m_wip [4];
  logic [7:0] m_pre [4][4];
  logic       m_act = 1'b0;
  logic [1:0] m_tgt = '0;
  logic       e_rdv = 1'b0;
  logic [7:0] e_rdd = '0;
  logic       wip_known = 1'b0;

  always #10 clk = ~clk;

  wiper_bank dut (.*);

  initial begin
    #4000000;
    miss++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  function automatic logic pre_wr(input logic [3:0] op);
    return op == 4'd3 || op == 4'd5 || op == 4'd7;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle, predict, then compare at the next falling edge
  task automatic cyc(input logic rst, input logic v, input logic [3:0] op, input logic [1:0] pot,
                     input logic [1:0] sel, input logic [7:0] d, input logic g,
                     input logic pl, input logic up, input logic se, input string req);
    logic rdy, tk;
    logic [7:0] ow [4];
    logic [7:0] op_ [4][4];
    rst_n = rst; cmd_valid = v; cmd_op = op; cmd_pot = pot; cmd_sel = sel;
    cmd_data = d; nv_grant = g; step_pulse = pl; step_up = up; sel_end = se;
    #1;
    rdy = rst && (!pre_wr(op) || g);
    chk({req, "/R4 ready"}, {31'd0, cmd_ready}, {31'd0, rdy});
    tk = v && rdy;
    ow = m_wip; op_ = m_pre;
    if (!rst) begin
      for (int p = 0; p < 4; p++) m_wip[p] = op_[p][0];
      m_act = 1'b0; e_rdv = 1'b0; e_rdd = 8'd0;
    end else begin
      e_rdv = tk && (op == 4'd0 || op == 4'd2);
      if (e_rdv) e_rdd = (op == 4'd0) ? ow[pot] : op_[pot][sel];
      for (int p = 0; p < 4; p++) begin
        logic ld;
        ld = tk && (((op == 4'd1 || op == 4'd4) && pot == 2'(p)) || op == 4'd6);
        if (ld) m_wip[p] = (op == 4'd1) ? d : op_[p][sel];
        else if (m_act && pl && m_tgt == 2'(p)) begin
          if (up && ow[p] != 8'hFF) m_wip[p] = ow[p] + 8'd1;
          else if (!up && ow[p] != 8'h00) m_wip[p] = ow[p] - 8'd1;
        end
        if (tk && (((op == 4'd3 || op == 4'd5) && pot == 2'(p)) || op == 4'd7))
          m_pre[p][sel] = (op == 4'd3) ? d : ow[p];
      end
      if (se) m_act = 1'b0;
      else if (tk && op == 4'd8) begin m_act = 1'b1; m_tgt = pot; end
    end
    @(posedge clk); @(negedge clk);
    if (!rst) wip_known = 1'b1;
    if (wip_known)
      chk(req, wiper_codes, {m_wip[3], m_wip[2], m_wip[1], m_wip[0]});
    chk({req, "/R3 rd_valid"}, {31'd0, rd_valid}, {31'd0, e_rdv});
    if (e_rdv) chk({req, "/R3 rd_data"}, {24'd0, rd_data}, {24'd0, e_rdd});
  endtask

  task automatic cmd(input logic [3:0] op, input logic [1:0] pot, input logic [1:0] sel,
                     input logic [7:0] d, input string req);
    cyc(1, 1, op, pot, sel, d, 1, 0, 0, 0, req);
  endtask

  task automatic pulse(input logic up, input string req);
    cyc(1, 0, 0, 0, 0, 0, 0, 1, up, 0, req);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < 4; p++) begin m_wip[p] = 'x; for (int s = 0; s < 4; s++) m_pre[p][s] = 'x; end
    @(negedge clk);
    // reset state: ready low, no read result (R1)
    cyc(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R1 reset");
    wip_known = 1'b0;
    // fill presets with distinct values (R6, R12 slot encoding)
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        cmd(4'd3, 2'(p), 2'(s), 8'(16 * p + 3 * s + 5), "R6 preset write");
    // recall at reset (R1)
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 recall");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 recall");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 after release");
    // read preset slots 0 and 3 (R3, R12)
    cmd(4'd2, 2'd2, 2'd0, 0, "R12 read slot0");
    cmd(4'd2, 2'd2, 2'd3, 0, "R12 read slot3");
    cmd(4'd1, 2'd1, 0, 8'hA7, "R2 write wiper");
    cmd(4'd0, 2'd1, 0, 0, "R3 read wiper");
    cmd(4'd4, 2'd3, 2'd2, 0, "R5 preset to wiper");
    cmd(4'd5, 2'd1, 2'd1, 0, "R6 wiper to preset");
    cmd(4'd2, 2'd1, 2'd1, 0, "R6 readback");
    cmd(4'd6, 2'd2, 2'd3, 0, "R7 global to wipers");
    cmd(4'd1, 2'd0, 0, 8'h11, "R2 write wiper");
    cmd(4'd7, 2'd3, 2'd2, 0, "R8 global to presets");
    for (int p = 0; p < 4; p++) cmd(4'd2, 2'(p), 2'd2, 0, "R8 readback");
    // stall without grant (R4)
    for (int i = 0; i < 3; i++) cyc(1, 1, 4'd3, 2'd0, 2'd0, 8'h99, 0, 0, 0, 0, "R4 stall");
    cmd(4'd2, 2'd0, 2'd0, 0, "R4 unchanged");
    cyc(1, 1, 4'd3, 2'd0, 2'd0, 8'h99, 1, 0, 0, 0, "R4 granted");
    // pulses outside step mode (R11)
    pulse(1, "R11 idle pulse"); pulse(0, "R11 idle pulse");
    // saturation up (R9, R10)
    cmd(4'd1, 2'd2, 0, 8'hFE, "R2 preload");
    cmd(4'd8, 2'd2, 0, 0, "R9 enter");
    for (int i = 0; i < 3; i++) pulse(1, "R10 up sat");
    cmd(4'd1, 2'd2, 0, 8'h01, "R2 preload");
    for (int i = 0; i < 3; i++) pulse(0, "R10 down sat");
    // load beats step in same cycle (R9)
    cyc(1, 1, 4'd1, 2'd2, 0, 8'h40, 1, 1, 1, 0, "R9 load priority");
    cyc(1, 0, 0, 0, 0, 0, 0, 1, 1, 1, "R11 exit");
    pulse(1, "R11 after exit");
    // unused op codes (R12)
    for (int c = 9; c < 16; c++) cmd(4'(c), 2'(c), 2'(c), 8'hFF, "R12 unused op");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 10));
      cyc(($urandom_range(0, 99) != 0), ($urandom_range(0, 3) != 0), op,
          2'($urandom), 2'($urandom), 8'($urandom), ($urandom_range(0, 2) != 0),
          ($urandom_range(0, 1) == 1), ($urandom_range(0, 2) != 0),
          ($urandom_range(0, 19) == 0), "R2/R5/R7/R8/R9/R10 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule